// File: doc/BRIEF.md
# Interrupt Acceptance and Flag Unit

This block keeps the three pieces of processor status that govern interrupts: an interrupt-enable bit, a stack-select bit (0 picks the interrupt stack pointer, 1 the user stack pointer) and a 3-bit processor priority level (0 to 7). Each cycle it looks at three kinds of request. The first is a set of fixed-source strobes that always win. The second is a software-interrupt strobe carrying an interrupt number. The third is a maskable request carrying a level and a number. The unit decides whether any of them is taken.

When a request is taken, the unit raises a one-clock acknowledge and reports the source class and the vector address. In the same edge it latches the flags as they stood before the acknowledge, so the core can push them, and then updates the flags. Software can also load all three flags through a write port. Instruction execution, stacking and memory access belong to the surrounding core.

Top module: `irq_accept_unit`

## Requirements
- R1: A synchronous active-low reset clears the enable bit, the stack-select bit, the priority level, the acknowledge output and the source code to 0.
- R2: With no request taken, a flag write loads the enable bit, stack-select bit and priority level, visible one clock later.
- R3: A maskable request is taken only when the enable bit is 1 and its level is strictly greater than the priority level.
- R4: Every acknowledge clears the enable bit to 0 and leaves the priority level unchanged.
- R5: The stack-select bit is cleared on acknowledge of a fixed-source or maskable request, and of a software interrupt numbered 0 to 31. Software numbers 32 and above leave it unchanged.
- R6: Fixed-source slots are undefined instruction (0), overflow (1), break (2), address match (3), single step (4), watchdog/oscillator/voltage monitor (5), reserved (6, 7) and reset (8). Their vector is 0FFDCh plus 4 times the slot. They ignore the enable bit and the level compare.
- R7: Among fixed-source strobes in one cycle, the highest slot index wins, so reset beats watchdog, which beats the lower slots. Strobes on reserved slots 6 and 7 are ignored.
- R8: Class precedence is fixed, then software, then maskable. A software or maskable vector is VAR_BASE plus 4 times its number.
- R9: The acknowledge is a one-clock pulse in the cycle after the request. The source code is 1 for fixed, 2 for software and 3 for maskable. The saved-flag outputs hold the flag values from before the acknowledge.
- R10: A flag write in the same cycle as a taken request is discarded: the acknowledge updates win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flag_wr_en | input | 1 | Load the three flags from the write inputs |
| flag_wr_int_en | input | 1 | New enable bit |
| flag_wr_stk_sel | input | 1 | New stack-select bit |
| flag_wr_prio | input | 3 | New priority level |
| mask_req | input | 1 | Maskable request |
| mask_lvl | input | 3 | Level of the maskable request |
| mask_num | input | NUM_W | Vector number of the maskable request |
| fix_req | input | 9 | Fixed-source strobes, one per slot |
| sw_req | input | 1 | Software-interrupt strobe |
| sw_num | input | NUM_W | Software interrupt number |
| int_en | output | 1 | Interrupt-enable bit |
| stk_sel | output | 1 | Stack-select bit |
| prio_lvl | output | 3 | Processor priority level |
| ack | output | 1 | Acknowledge pulse |
| ack_src | output | 2 | Source class of the acknowledge |
| ack_vec | output | 20 | Vector address of the acknowledged request |
| sv_int_en | output | 1 | Enable bit before the last acknowledge |
| sv_stk_sel | output | 1 | Stack-select bit before the last acknowledge |
| sv_prio | output | 3 | Priority level before the last acknowledge |

## Verification
The bench builds the unit with NUM_W = 6 and VAR_BASE = 0FE00h. A 6-bit number reaches both sides of the 31/32 boundary that decides whether software interrupts touch the stack-select bit. It also reaches number 63, so the largest variable vector, 0FEFCh, lies just below the fixed table and cannot be mistaken for a fixed entry. The stimulus also covers equal request and processor levels, reserved-slot strobes, all three classes arriving together, and a flag write that collides with an acknowledge.

// File: rtl/irq_accept_pkg.sv
// Shared constants and types for the interrupt acceptance unit.
// Assumes a 20-bit address space and a fixed table of nine 4-byte slots.
package irq_accept_pkg;

    localparam int ADDR_W    = 20;
    localparam int LVL_W     = 3;
    localparam int FIX_N     = 9;
    localparam int FIX_IDX_W = $clog2(FIX_N);

    // Slot indices that carry meaning for precedence
    localparam int SLOT_WDOG  = 5;
    localparam int SLOT_RESET = 8;

    // Reserved slots whose strobes are dropped
    localparam logic [FIX_N-1:0] FIX_RSVD = 9'b0_1100_0000;

    localparam logic [ADDR_W-1:0] FIX_TBL_BASE = 20'h0FFDC;

    // Software numbers below this limit clear the stack-select bit
    localparam int SW_STK_LIMIT = 32;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_FIXED = 2'd1,
        SRC_SOFT  = 2'd2,
        SRC_MASK  = 2'd3
    } src_e;

endpackage

// File: rtl/irq_fixed_arb.sv
// Fixed-source arbiter.
// Drops reserved slots, then picks the highest-index live strobe.
// Assumes the slot index order is the precedence order (reset on top).
module irq_fixed_arb
    import irq_accept_pkg::*;
(
    input  logic [FIX_N-1:0]     req_i,
    output logic                 hit_o,
    output logic [FIX_IDX_W-1:0] slot_o
);

    logic [FIX_N-1:0] live;

    // Mask off reserved slots, one gate per slot
    for (genvar g = 0; g < FIX_N; g++) begin : g_live
        if (FIX_RSVD[g]) begin : g_rsvd
            assign live[g] = 1'b0;
        end else begin : g_used
            assign live[g] = req_i[g];
        end
    end

    // Highest live slot wins: later loop iterations override earlier ones
    always_comb begin
        hit_o  = |live;
        slot_o = '0;
        for (int k = 0; k < FIX_N; k++) begin
            if (live[k]) slot_o = FIX_IDX_W'(k);
        end
    end

endmodule

// File: rtl/irq_decide.sv
// Acceptance decision.
// Chooses between the fixed, software and maskable classes and forms the
// vector and the stack-select clear for the chosen request.
// Assumes fixed beats software beats maskable, and that maskable requests
// need the enable bit plus a level strictly above the processor level.
module irq_decide
    import irq_accept_pkg::*;
#(
    parameter int                NUM_W    = 6,
    parameter logic [ADDR_W-1:0] VAR_BASE = 20'h0FE00
) (
    input  logic                 int_en_i,
    input  logic [LVL_W-1:0]     prio_i,
    input  logic                 fix_hit_i,
    input  logic [FIX_IDX_W-1:0] fix_slot_i,
    input  logic                 sw_req_i,
    input  logic [NUM_W-1:0]     sw_num_i,
    input  logic                 mask_req_i,
    input  logic [LVL_W-1:0]     mask_lvl_i,
    input  logic [NUM_W-1:0]     mask_num_i,
    output logic                 take_o,
    output src_e                 src_o,
    output logic [ADDR_W-1:0]    vec_o,
    output logic                 clr_stk_o
);

    logic              mask_ok;
    logic              sw_low;
    logic [ADDR_W-1:0] fix_vec;
    logic [ADDR_W-1:0] sw_vec;
    logic [ADDR_W-1:0] mask_vec;

    // Maskable gate: enable bit and strict level compare
    always_comb mask_ok = mask_req_i && int_en_i && (mask_lvl_i > prio_i);

    // Software numbers in the low range force the interrupt stack
    always_comb sw_low = int'(sw_num_i) < SW_STK_LIMIT;

    // Vector addresses for each class, 4 bytes per entry
    always_comb begin
        fix_vec  = FIX_TBL_BASE + ADDR_W'({fix_slot_i, 2'b00});
        sw_vec   = VAR_BASE + ADDR_W'({sw_num_i, 2'b00});
        mask_vec = VAR_BASE + ADDR_W'({mask_num_i, 2'b00});
    end

    // Class precedence select
    always_comb begin
        take_o    = 1'b0;
        src_o     = SRC_NONE;
        vec_o     = '0;
        clr_stk_o = 1'b0;
        if (fix_hit_i) begin
            take_o    = 1'b1;
            src_o     = SRC_FIXED;
            vec_o     = fix_vec;
            clr_stk_o = 1'b1;
        end else if (sw_req_i) begin
            take_o    = 1'b1;
            src_o     = SRC_SOFT;
            vec_o     = sw_vec;
            clr_stk_o = sw_low;
        end else if (mask_ok) begin
            take_o    = 1'b1;
            src_o     = SRC_MASK;
            vec_o     = mask_vec;
            clr_stk_o = 1'b1;
        end
    end

endmodule

// File: rtl/irq_flag_regs.sv
// Flag and acknowledge registers.
// Holds the enable bit, the stack-select bit and the priority level, and
// registers the acknowledge, its source, its vector and the saved flags.
// Assumes an acknowledge always beats a flag write in the same cycle.
module irq_flag_regs
    import irq_accept_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              wr_int_en_i,
    input  logic              wr_stk_sel_i,
    input  logic [LVL_W-1:0]  wr_prio_i,
    input  logic              take_i,
    input  src_e              src_i,
    input  logic [ADDR_W-1:0] vec_i,
    input  logic              clr_stk_i,
    output logic              int_en_o,
    output logic              stk_sel_o,
    output logic [LVL_W-1:0]  prio_o,
    output logic              ack_o,
    output src_e              src_o,
    output logic [ADDR_W-1:0] vec_o,
    output logic              sv_int_en_o,
    output logic              sv_stk_sel_o,
    output logic [LVL_W-1:0]  sv_prio_o
);

    // Flag update: reset, then acknowledge, then direct write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_en_o  <= 1'b0;
            stk_sel_o <= 1'b0;
            prio_o    <= '0;
        end else if (take_i) begin
            int_en_o <= 1'b0;
            if (clr_stk_i) stk_sel_o <= 1'b0;
        end else if (wr_en_i) begin
            int_en_o  <= wr_int_en_i;
            stk_sel_o <= wr_stk_sel_i;
            prio_o    <= wr_prio_i;
        end
    end

    // Acknowledge pulse and source code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_o <= 1'b0;
            src_o <= SRC_NONE;
        end else begin
            ack_o <= take_i;
            src_o <= take_i ? src_i : SRC_NONE;
        end
    end

    // Vector and pre-acknowledge flag snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_o        <= '0;
            sv_int_en_o  <= 1'b0;
            sv_stk_sel_o <= 1'b0;
            sv_prio_o    <= '0;
        end else if (take_i) begin
            vec_o        <= vec_i;
            sv_int_en_o  <= int_en_o;
            sv_stk_sel_o <= stk_sel_o;
            sv_prio_o    <= prio_o;
        end
    end

    // R4
    ack_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> !int_en_o);

    // R4
    ack_keeps_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> prio_o == $past(prio_o));

    // R9
    saved_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (sv_int_en_o == $past(int_en_o)) && (sv_stk_sel_o == $past(stk_sel_o))
                  && (sv_prio_o == $past(prio_o)));

    // R9
    src_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o == (src_o != SRC_NONE));

endmodule

// File: rtl/irq_accept_unit.sv
// Interrupt acceptance and flag unit (top).
// Joins the fixed-source arbiter, the class decision and the flag
// registers. Assumes request strobes last one cycle each.
module irq_accept_unit
    import irq_accept_pkg::*;
#(
    parameter int                NUM_W    = 6,
    parameter logic [ADDR_W-1:0] VAR_BASE = 20'h0FE00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_wr_en,
    input  logic              flag_wr_int_en,
    input  logic              flag_wr_stk_sel,
    input  logic [LVL_W-1:0]  flag_wr_prio,
    input  logic              mask_req,
    input  logic [LVL_W-1:0]  mask_lvl,
    input  logic [NUM_W-1:0]  mask_num,
    input  logic [FIX_N-1:0]  fix_req,
    input  logic              sw_req,
    input  logic [NUM_W-1:0]  sw_num,
    output logic              int_en,
    output logic              stk_sel,
    output logic [LVL_W-1:0]  prio_lvl,
    output logic              ack,
    output logic [1:0]        ack_src,
    output logic [ADDR_W-1:0] ack_vec,
    output logic              sv_int_en,
    output logic              sv_stk_sel,
    output logic [LVL_W-1:0]  sv_prio
);

    logic                 fix_hit;
    logic [FIX_IDX_W-1:0] fix_slot;
    logic                 take;
    src_e                 take_src;
    logic [ADDR_W-1:0]    take_vec;
    logic                 clr_stk;
    src_e                 src_q;

    irq_fixed_arb u_arb (
        .req_i  (fix_req),
        .hit_o  (fix_hit),
        .slot_o (fix_slot)
    );

    irq_decide #(.NUM_W(NUM_W), .VAR_BASE(VAR_BASE)) u_dec (
        .int_en_i   (int_en),
        .prio_i     (prio_lvl),
        .fix_hit_i  (fix_hit),
        .fix_slot_i (fix_slot),
        .sw_req_i   (sw_req),
        .sw_num_i   (sw_num),
        .mask_req_i (mask_req),
        .mask_lvl_i (mask_lvl),
        .mask_num_i (mask_num),
        .take_o     (take),
        .src_o      (take_src),
        .vec_o      (take_vec),
        .clr_stk_o  (clr_stk)
    );

    irq_flag_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (flag_wr_en),
        .wr_int_en_i  (flag_wr_int_en),
        .wr_stk_sel_i (flag_wr_stk_sel),
        .wr_prio_i    (flag_wr_prio),
        .take_i       (take),
        .src_i        (take_src),
        .vec_i        (take_vec),
        .clr_stk_i    (clr_stk),
        .int_en_o     (int_en),
        .stk_sel_o    (stk_sel),
        .prio_o       (prio_lvl),
        .ack_o        (ack),
        .src_o        (src_q),
        .vec_o        (ack_vec),
        .sv_int_en_o  (sv_int_en),
        .sv_stk_sel_o (sv_stk_sel),
        .sv_prio_o    (sv_prio)
    );

    // Source code to the port
    always_comb ack_src = src_q;

    // R3
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && src_q == SRC_MASK) |->
            ($past(mask_req) && $past(int_en) && ($past(mask_lvl) > $past(prio_lvl))));

    // R5
    hw_clears_stk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && src_q != SRC_SOFT) |-> !stk_sel);

    // R6
    fixed_vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && src_q == SRC_FIXED) |-> (ack_vec >= FIX_TBL_BASE) && (ack_vec[1:0] == 2'b00));

    // R7
    no_reserved_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && src_q == SRC_FIXED) |->
            (ack_vec != FIX_TBL_BASE + 20'd24) && (ack_vec != FIX_TBL_BASE + 20'd28));

    // R8
    fixed_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(|(fix_req & ~FIX_RSVD)) && ack) |-> src_q == SRC_FIXED);

endmodule

// File: tb/sim_irq_accept_unit.sv
// Bench for the interrupt acceptance unit: a vector table walked by one
// loop, then directed tests for reset and the write/acknowledge collision.
module sim_irq_accept_unit;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n;
    logic        wr_en, wr_i, wr_u;
    logic [2:0]  wr_p;
    logic        mreq;
    logic [2:0]  mlvl;
    logic [5:0]  mnum;
    logic [8:0]  fix;
    logic        swr;
    logic [5:0]  swn;
    logic        o_i, o_u, o_ack, s_i, s_u;
    logic [2:0]  o_p, s_p;
    logic [1:0]  o_src;
    logic [19:0] o_vec;

    int checks = 0;
    int fails  = 0;

    irq_accept_unit #(.NUM_W(6), .VAR_BASE(20'h0FE00)) u0 (
        .clk(clk), .rst_n(rst_n),
        .flag_wr_en(wr_en), .flag_wr_int_en(wr_i), .flag_wr_stk_sel(wr_u), .flag_wr_prio(wr_p),
        .mask_req(mreq), .mask_lvl(mlvl), .mask_num(mnum),
        .fix_req(fix), .sw_req(swr), .sw_num(swn),
        .int_en(o_i), .stk_sel(o_u), .prio_lvl(o_p),
        .ack(o_ack), .ack_src(o_src), .ack_vec(o_vec),
        .sv_int_en(s_i), .sv_stk_sel(s_u), .sv_prio(s_p)
    );

    typedef struct packed {
        logic        wi;  logic wu; logic [2:0] wp;
        logic [8:0]  fx;
        logic        sr;  logic [5:0] sn;
        logic        mr;  logic [2:0] ml; logic [5:0] mn;
        logic        eack; logic [1:0] esrc; logic [19:0] evec;
        logic        ei;  logic eu; logic [2:0] ep;
    } row_t;

    localparam int NROW = 13;
    localparam row_t TBL [NROW] = '{
        '{1'b1,1'b1,3'd3, 9'h000, 1'b0,6'd0,  1'b1,3'd4,6'd5,  1'b1,2'd3,20'h0FE14, 1'b0,1'b0,3'd3}, // R3 R8 accepted
        '{1'b1,1'b1,3'd4, 9'h000, 1'b0,6'd0,  1'b1,3'd4,6'd5,  1'b0,2'd0,20'h00000, 1'b1,1'b1,3'd4}, // R3 equal level
        '{1'b0,1'b1,3'd0, 9'h000, 1'b0,6'd0,  1'b1,3'd7,6'd9,  1'b0,2'd0,20'h00000, 1'b0,1'b1,3'd0}, // R3 disabled
        '{1'b0,1'b1,3'd7, 9'h001, 1'b0,6'd0,  1'b0,3'd0,6'd0,  1'b1,2'd1,20'h0FFDC, 1'b0,1'b0,3'd7}, // R6 bypass
        '{1'b1,1'b1,3'd2, 9'h011, 1'b0,6'd0,  1'b0,3'd0,6'd0,  1'b1,2'd1,20'h0FFEC, 1'b0,1'b0,3'd2}, // R7 slot4
        '{1'b1,1'b0,3'd6, 9'h130, 1'b0,6'd0,  1'b0,3'd0,6'd0,  1'b1,2'd1,20'h0FFFC, 1'b0,1'b0,3'd6}, // R7 reset
        '{1'b1,1'b1,3'd1, 9'h030, 1'b0,6'd0,  1'b0,3'd0,6'd0,  1'b1,2'd1,20'h0FFF0, 1'b0,1'b0,3'd1}, // R7 watchdog
        '{1'b1,1'b1,3'd5, 9'h0C0, 1'b0,6'd0,  1'b0,3'd0,6'd0,  1'b0,2'd0,20'h00000, 1'b1,1'b1,3'd5}, // R7 reserved
        '{1'b1,1'b1,3'd0, 9'h000, 1'b1,6'd31, 1'b0,3'd0,6'd0,  1'b1,2'd2,20'h0FE7C, 1'b0,1'b0,3'd0}, // R5 sw 31
        '{1'b1,1'b1,3'd0, 9'h000, 1'b1,6'd32, 1'b0,3'd0,6'd0,  1'b1,2'd2,20'h0FE80, 1'b0,1'b1,3'd0}, // R5 sw 32
        '{1'b1,1'b1,3'd0, 9'h000, 1'b1,6'd40, 1'b1,3'd7,6'd3,  1'b1,2'd2,20'h0FEA0, 1'b0,1'b1,3'd0}, // R8 sw>mask
        '{1'b1,1'b1,3'd0, 9'h002, 1'b1,6'd10, 1'b1,3'd7,6'd3,  1'b1,2'd1,20'h0FFE0, 1'b0,1'b0,3'd0}, // R8 fixed first
        '{1'b1,1'b0,3'd0, 9'h000, 1'b0,6'd0,  1'b1,3'd1,6'd63, 1'b1,2'd3,20'h0FEFC, 1'b0,1'b0,3'd0}  // R8 top number
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_i = 0; wr_u = 0; wr_p = 0;
        mreq = 0; mlvl = 0; mnum = 0; fix = 0; swr = 0; swn = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 int_en", o_i, 0); chk("R1 stk_sel", o_u, 0);
        chk("R1 prio", o_p, 0);   chk("R1 ack", o_ack, 0); chk("R1 src", o_src, 0);
        rst_n = 1;

        // R2 plain write
        wr_en = 1; wr_i = 1; wr_u = 0; wr_p = 3'd5;
        @(negedge clk);
        wr_en = 0;
        chk("R2 int_en", o_i, 1); chk("R2 stk_sel", o_u, 0); chk("R2 prio", o_p, 5);

        for (int r = 0; r < NROW; r++) begin
            wr_en = 1; wr_i = TBL[r].wi; wr_u = TBL[r].wu; wr_p = TBL[r].wp;
            @(negedge clk);
            wr_en = 0;
            fix = TBL[r].fx; swr = TBL[r].sr; swn = TBL[r].sn;
            mreq = TBL[r].mr; mlvl = TBL[r].ml; mnum = TBL[r].mn;
            @(negedge clk);
            idle();
            chk("R9 ack", o_ack, TBL[r].eack);
            chk("R9 src", o_src, TBL[r].esrc);
            chk("R4 int_en", o_i, TBL[r].ei);
            chk("R5 stk_sel", o_u, TBL[r].eu);
            chk("R4 prio", o_p, TBL[r].ep);
            if (TBL[r].eack) begin
                chk("R8 vector", o_vec, TBL[r].evec);
                chk("R9 saved int_en", s_i, TBL[r].wi);
                chk("R9 saved stk_sel", s_u, TBL[r].wu);
                chk("R9 saved prio", s_p, TBL[r].wp);
            end
            @(negedge clk);
            chk("R9 pulse ends", o_ack, 0);
        end

        // R10 write collides with an acknowledge
        wr_en = 1; wr_i = 1; wr_u = 1; wr_p = 3'd2;
        @(negedge clk);
        wr_i = 1; wr_u = 1; wr_p = 3'd6; fix = 9'h008;
        @(negedge clk);
        idle();
        chk("R10 ack", o_ack, 1); chk("R10 vector", o_vec, 20'h0FFE8);
        chk("R10 int_en", o_i, 0); chk("R10 stk_sel", o_u, 0); chk("R10 prio", o_p, 2);

        // R1 reset mid-run
        wr_en = 1; wr_i = 1; wr_u = 1; wr_p = 3'd7;
        @(negedge clk);
        idle(); rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        chk("R1 late int_en", o_i, 0); chk("R1 late stk_sel", o_u, 0); chk("R1 late prio", o_p, 0);

        @(negedge clk);
        finish_run();
    end

endmodule